// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Alarm

This block keeps wall-clock time for a chip that already has a one-second tick. Seconds, minutes and hours are held as packed BCD bytes. Days are held as a flat 15-bit binary count. Converting the day count to a month and year is left to software. The counter advances by one second on each cycle where the `sec_tick` enable is high and the run bit of the control register is set.

Software reaches the time, the alarm and the control register through a byte-wide register port. Writes take one cycle; reads are combinational from `rd_addr`. A busy indication is raised on the cycle in which the tick moves through the fields. Software polls this bit before it touches a time or alarm register, because writes to those registers are dropped during that cycle.

The alarm compares minute, hour and day against programmed values. Each of the three fields has its own enable. The alarm is checked only on the tick that brings seconds to 00. When it matches, it sets a sticky flag. Software clears the flag by writing a one to it. The interrupt request is the flag gated by an interrupt enable.

Top module: `tod_calendar`

## Requirements
- R1: Seconds (address 1) and minutes (address 2) count in BCD from 0x00 to 0x59. On a counting tick, 0x59 goes to 0x00 and carries into the next field.
- R2: Hours (address 3) count in BCD from 0x00 to 0x23. A carry out of 0x23 returns hours to 0x00 and adds one to the day count.
- R3: The day count is 15-bit binary. It reads as a low byte at address 4 and as bits 14:8 at address 5, where bit 7 of address 5 always reads 0. It wraps from 0x7FFF to 0.
- R4: A tick advances time only while control bit 0 (run) is 1. A tick with run at 0 leaves every time field unchanged.
- R5: The `busy` output and control bit 7 are high exactly in a cycle with `sec_tick`=1 and run=1. A write to addresses 1 to 9 in that cycle is ignored. A control write in that cycle is accepted.
- R6: The alarm flag (control bit 2) sets on a counting tick whose new seconds value is 0x00, provided every enabled field matches. The field enables are bit 3 for minute, bit 4 for hour and bit 5 for day. The values are compared against alarm minute (address 6), alarm hour (address 7) and alarm day (addresses 8 and 9, with the same split as the day count). A disabled field is not compared.
- R7: Writing control with bit 2 at 1 clears the alarm flag. Writing it with bit 2 at 0 leaves the flag unchanged. If the flag sets and clears in the same cycle, the set wins.
- R8: `alarm_irq` equals the alarm flag ANDed with control bit 1.
- R9: The control register is at address 0 and its bits 5, 4, 3, 1 and 0 read back as written. A write to addresses 1 to 9 outside a busy cycle reads back from the next cycle. Seconds and minutes keep bits 6:0 of the written byte and hours keep bits 5:0. Addresses 10 to 15 read 0.
- R10: After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-second advance enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| busy | output | 1 | High on the cycle a tick updates the time |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The reference model is driven through several patterns, each of which tells apart a different failure:
- Isolated ticks near 59 seconds separate the seconds carry from the minutes carry.
- Starting from 23:59:57 with the day at 0x7FFF checks the hour rollover, the day increment and the 15-bit wrap at once.
- Ticks with run cleared, and writes landing on a tick cycle, show whether state is held or whether a write slipped through a busy cycle.
- Alarm runs with only the minute enable, with a mismatched hour enabled, with a clear landing on the very tick that sets the flag, and with the interrupt enable toggled. These separate field masking, set-over-clear priority and interrupt gating.
- A long free run with a day alarm then covers many rollovers.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int DAY_W    = 15;
    localparam int DAY_HI_W = DAY_W - BYTE_W;

    localparam logic [BYTE_W-1:0] SEC_LAST  = 8'h59;
    localparam logic [BYTE_W-1:0] MIN_LAST  = 8'h59;
    localparam logic [BYTE_W-1:0] HOUR_LAST = 8'h23;
    localparam logic [BYTE_W-1:0] MS_MASK   = 8'h7F;
    localparam logic [BYTE_W-1:0] HR_MASK   = 8'h3F;

    // control register bit positions (software decodes these)
    localparam int CB_RUN   = 0;
    localparam int CB_IRQEN = 1;
    localparam int CB_FLAG  = 2;
    localparam int CB_MINEN = 3;
    localparam int CB_HREN  = 4;
    localparam int CB_DAYEN = 5;
    localparam int CB_BUSY  = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 4'd0,
        RA_SEC   = 4'd1,
        RA_MIN   = 4'd2,
        RA_HOUR  = 4'd3,
        RA_DLO   = 4'd4,
        RA_DHI   = 4'd5,
        RA_AMIN  = 4'd6,
        RA_AHOUR = 4'd7,
        RA_ADLO  = 4'd8,
        RA_ADHI  = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [DAY_W-1:0]  day;
    } tod_t;

    typedef struct packed {
        logic day_en;
        logic hour_en;
        logic min_en;
        logic irq_en;
        logic run;
    } ctrl_t;

    // BCD increment with wrap to zero after 'last'
    function automatic logic [BYTE_W-1:0] bcd_next(input logic [BYTE_W-1:0] v,
                                                   input logic [BYTE_W-1:0] last);
        if (v == last)
            return '0;
        else if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction
endpackage

// File: rtl/tod_time_chain.sv
module tod_time_chain
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output tod_t              cur,
    output tod_t              nxt
);
    logic c_sec, c_min, c_hour;

    always_comb begin
        c_sec      = (cur.sec == SEC_LAST);
        c_min      = c_sec && (cur.min == MIN_LAST);
        c_hour     = c_min && (cur.hour == HOUR_LAST);
        nxt.sec    = bcd_next(cur.sec, SEC_LAST);
        nxt.min    = c_sec ? bcd_next(cur.min, MIN_LAST) : cur.min;
        nxt.hour   = c_min ? bcd_next(cur.hour, HOUR_LAST) : cur.hour;
        nxt.day    = c_hour ? cur.day + DAY_W'(1) : cur.day;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (step) begin
            cur <= nxt;
        end else if (wr_en) begin
            case (wr_addr)
                RA_SEC:  cur.sec          <= wr_data & MS_MASK;
                RA_MIN:  cur.min          <= wr_data & MS_MASK;
                RA_HOUR: cur.hour         <= wr_data & HR_MASK;
                RA_DLO:  cur.day[BYTE_W-1:0] <= wr_data;
                RA_DHI:  cur.day[DAY_W-1:BYTE_W] <= wr_data[DAY_HI_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  tod_t              nxt,
    input  ctrl_t             ctrl,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_clr,
    output logic [BYTE_W-1:0] al_min,
    output logic [BYTE_W-1:0] al_hour,
    output logic [DAY_W-1:0]  al_day,
    output logic              flag
);
    logic hit;

    always_comb begin
        hit = step && (nxt.sec == '0)
            && (!ctrl.min_en  || (nxt.min  == al_min))
            && (!ctrl.hour_en || (nxt.hour == al_hour))
            && (!ctrl.day_en  || (nxt.day  == al_day));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            al_min  <= '0;
            al_hour <= '0;
            al_day  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_AMIN:  al_min  <= wr_data & MS_MASK;
                RA_AHOUR: al_hour <= wr_data & HR_MASK;
                RA_ADLO:  al_day[BYTE_W-1:0] <= wr_data;
                RA_ADHI:  al_day[DAY_W-1:BYTE_W] <= wr_data[DAY_HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (hit)      flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              busy,
    output logic              alarm_irq
);
    localparam int HI_PAD = BYTE_W - DAY_HI_W;

    ctrl_t             ctrl;
    tod_t              cur_time, nxt_time;
    logic [BYTE_W-1:0] al_min, al_hour;
    logic [DAY_W-1:0]  al_day;
    logic              alarm_flag;
    logic              step, reg_wr, ctrl_wr;

    assign step    = sec_tick && ctrl.run;
    assign busy    = step;
    assign reg_wr  = wr_en && !step;
    assign ctrl_wr = wr_en && (wr_addr == RA_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.run     <= wr_data[CB_RUN];
            ctrl.irq_en  <= wr_data[CB_IRQEN];
            ctrl.min_en  <= wr_data[CB_MINEN];
            ctrl.hour_en <= wr_data[CB_HREN];
            ctrl.day_en  <= wr_data[CB_DAYEN];
        end
    end

    tod_time_chain u_chain (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .wr_en   (reg_wr),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cur     (cur_time),
        .nxt     (nxt_time)
    );

    tod_alarm u_alarm (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .nxt      (nxt_time),
        .ctrl     (ctrl),
        .wr_en    (reg_wr),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .flag_clr (ctrl_wr && wr_data[CB_FLAG]),
        .al_min   (al_min),
        .al_hour  (al_hour),
        .al_day   (al_day),
        .flag     (alarm_flag)
    );

    assign alarm_irq = alarm_flag && ctrl.irq_en;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL: begin
                rd_data[CB_BUSY]  = busy;
                rd_data[CB_DAYEN] = ctrl.day_en;
                rd_data[CB_HREN]  = ctrl.hour_en;
                rd_data[CB_MINEN] = ctrl.min_en;
                rd_data[CB_FLAG]  = alarm_flag;
                rd_data[CB_IRQEN] = ctrl.irq_en;
                rd_data[CB_RUN]   = ctrl.run;
            end
            RA_SEC:   rd_data = cur_time.sec;
            RA_MIN:   rd_data = cur_time.min;
            RA_HOUR:  rd_data = cur_time.hour;
            RA_DLO:   rd_data = cur_time.day[BYTE_W-1:0];
            RA_DHI:   rd_data = {{HI_PAD{1'b0}}, cur_time.day[DAY_W-1:BYTE_W]};
            RA_AMIN:  rd_data = al_min;
            RA_AHOUR: rd_data = al_hour;
            RA_ADLO:  rd_data = al_day[BYTE_W-1:0];
            RA_ADHI:  rd_data = {{HI_PAD{1'b0}}, al_day[DAY_W-1:BYTE_W]};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk
    import tod_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              step,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input tod_t              cur,
    input logic              flag,
    input logic              irq
);
    p_sec_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (step && cur.sec == 8'h59) |=> (cur.sec == 8'h00));

    p_day_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (step && cur.sec == 8'h59 && cur.min == 8'h59 && cur.hour == 8'h23)
        |=> (cur.hour == 8'h00 && cur.day == DAY_W'($past(cur.day) + DAY_W'(1))));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!step && !wr_en) |=> $stable(cur));

    p_set_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(step));

    p_clear_by_write_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(wr_en && wr_addr == RA_CTRL && wr_data[CB_FLAG]));

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);
endmodule

bind tod_calendar tod_calendar_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cur     (cur_time),
    .flag    (alarm_flag),
    .irq     (alarm_irq)
);

// File: tb/tod_calendar_tb.sv
`timescale 1ns/1ps
module tod_calendar_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, alarm_irq;

    always #2.5 clk = ~clk;

    tod_calendar u_dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .alarm_irq(alarm_irq)
    );

    // behavioural reference state
    int ms, mm, mh, md;          // decimal time, binary day
    int am, ah, ad;              // alarm bytes as written (masked)
    int en, aien, men, hen, den, flg;
    int tests = 0, fails = 0, ncyc = 0;
    string ptag = "";

    function automatic int to_bcd(int v);
        return (v / 10) * 16 + (v % 10);
    endfunction
    function automatic int from_bcd(int b);
        return (b / 16) * 10 + (b % 16);
    endfunction

    function automatic int model_read(int a, int t);
        case (a)
            0: return (((t != 0 && en != 0) ? 1 : 0) << 7) | (den << 5) | (hen << 4)
                      | (men << 3) | (flg << 2) | (aien << 1) | en;
            1: return to_bcd(ms);
            2: return to_bcd(mm);
            3: return to_bcd(mh);
            4: return md & 8'hFF;
            5: return (md >> 8) & 8'h7F;
            6: return am;
            7: return ah;
            8: return ad & 8'hFF;
            9: return (ad >> 8) & 8'h7F;
            default: return 0;
        endcase
    endfunction

    function automatic string addr_tag(int a);
        if (ptag != "") return ptag;
        case (a)
            0: return "R7";
            1, 2: return "R1";
            3: return "R2";
            4, 5: return "R3";
            6, 7, 8, 9: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, ncyc);
        end
    endtask

    task automatic model_clock(int t, int w, int a, int d);
        int step, s, m, h, dy, hit, clr;
        step = (t != 0 && en != 0);
        s = ms; m = mm; h = mh; dy = md;
        if (step) begin
            s = ms + 1;
            if (s == 60) begin
                s = 0; m = mm + 1;
                if (m == 60) begin
                    m = 0; h = mh + 1;
                    if (h == 24) begin h = 0; dy = (md + 1) & 16'h7FFF; end
                end
            end
        end
        hit = step && s == 0 && (men == 0 || to_bcd(m) == am)
              && (hen == 0 || to_bcd(h) == ah) && (den == 0 || dy == ad);
        clr = (w != 0 && a == 0 && d[2]);
        if (step) begin
            ms = s; mm = m; mh = h; md = dy;
        end else if (w != 0) begin
            case (a)
                1: ms = from_bcd(d & 8'h7F);
                2: mm = from_bcd(d & 8'h7F);
                3: mh = from_bcd(d & 8'h3F);
                4: md = (md & 16'h7F00) | (d & 8'hFF);
                5: md = (md & 16'h00FF) | ((d & 8'h7F) << 8);
                6: am = d & 8'h7F;
                7: ah = d & 8'h3F;
                8: ad = (ad & 16'h7F00) | (d & 8'hFF);
                9: ad = (ad & 16'h00FF) | ((d & 8'h7F) << 8);
                default: ;
            endcase
        end
        if (w != 0 && a == 0) begin
            en = d[0]; aien = d[1]; men = d[3]; hen = d[4]; den = d[5];
        end
        if (hit) flg = 1;
        else if (clr) flg = 0;
    endtask

    task automatic cyc(int t, int w, int a, int d);
        int ra;
        ra = ncyc % 12;
        @(negedge clk);
        sec_tick = t[0]; wr_en = w[0]; wr_addr = a[3:0]; wr_data = d[7:0]; rd_addr = ra[3:0];
        #1;
        check("R5 busy", int'(busy), (t != 0 && en != 0) ? 1 : 0);
        check("R8 irq", int'(alarm_irq), (flg != 0 && aien != 0) ? 1 : 0);
        check(addr_tag(ra), int'(rd_data), model_read(ra, t));
        @(posedge clk);
        model_clock(t, w, a, d);
        ncyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic wr(int a, int d);
        cyc(0, 1, a, d);
    endtask

    task automatic tick_n(int n);
        for (int i = 0; i < n; i++) begin cyc(1, 0, 0, 0); cyc(0, 0, 0, 0); end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        ms = 0; mm = 0; mh = 0; md = 0; am = 0; ah = 0; ad = 0;
        en = 0; aien = 0; men = 0; hen = 0; den = 0; flg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        ptag = "R10"; idle(12);

        ptag = "R9";
        wr(0, 8'h01); wr(1, 8'h58); wr(2, 8'h59); wr(3, 8'h22);
        wr(4, 8'h34); wr(5, 8'h12); wr(6, 8'hD9); wr(7, 8'hC7);
        idle(12); wr(0, 8'h00); wr(0, 8'h01);

        ptag = "R1"; tick_n(6); idle(12);

        ptag = "R2";
        wr(3, 8'h23); wr(2, 8'h59); wr(1, 8'h57); wr(4, 8'hFF); wr(5, 8'hFF);
        tick_n(2); idle(6);
        ptag = "R3"; tick_n(3); idle(12);

        ptag = "R4"; wr(0, 8'h00);
        for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0);
        wr(0, 8'h01);

        ptag = "R5";
        cyc(1, 1, 1, 8'h30); cyc(1, 1, 6, 8'h11); cyc(1, 1, 4, 8'h55);
        idle(12);

        ptag = "R6";
        wr(6, 8'h02); wr(7, 8'h00); wr(8, 8'h00); wr(9, 8'h00);
        wr(1, 8'h58); wr(2, 8'h01); wr(3, 8'h00); wr(4, 8'h00); wr(5, 8'h00);
        wr(0, 8'h0B); tick_n(3); idle(12);

        ptag = "R7";
        wr(0, 8'h0B); idle(12); wr(0, 8'h0F); idle(12);
        wr(1, 8'h59); wr(2, 8'h01);
        cyc(1, 1, 0, 8'h0F); idle(12);

        ptag = "R8";
        wr(0, 8'h09); idle(12); wr(0, 8'h0B); idle(12);

        ptag = "R6";
        wr(0, 8'h1F); wr(7, 8'h05); wr(1, 8'h59); wr(2, 8'h01);
        tick_n(2); idle(12);

        ptag = "";
        wr(0, 8'h23);
        for (int i = 0; i < 3000; i++) cyc((i % 3 == 0) ? 1 : 0, 0, 0, 0);
        wr(0, 8'h27); idle(12);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule